// File: doc/BRIEF.md
# Triggered Multi-Shot Acquisition Sequencer

This block sequences sample capture for a multi-channel converter. The host writes command codes and shot settings through a small 32-bit register port. The block then counts pre-trigger samples, waits for a hardware or software trigger, counts post-trigger samples, and repeats this for a programmed number of shots. Samples from every channel arrive together, one per channel on each valid cycle. For each channel, two consecutive samples are packed into one 32-bit word, and the words for all channels are written as one slot of a circular buffer.

The sequencer has five states. Idle (code 0) moves to Pre-trigger Count (code 1) on START. Pre-trigger Count moves to Wait Trigger (code 2) once the pre-trigger count is reached. Wait Trigger moves to Wait End of Shot (code 3) when a trigger arrives. Wait End of Shot moves to Decrement Shot Count (code 4) once pre plus post samples have been counted. Decrement Shot Count goes back to Pre-trigger Count while shots remain, and otherwise goes to Idle. STOP forces Idle from any state. Each accepted trigger raises a one-cycle interrupt pulse. Completion of the final shot raises a separate one-cycle pulse.

Register map (word offsets, 3-bit address):
- 0: command. Written only; reads as 0.
- 1: state code.
- 2: pre-trigger count.
- 3: post-trigger count.
- 4: shot count.
- 5: sample counter.
- 6: shots remaining.
- 7: last write position.

Top module: `shot_sequencer`

## Requirements
- R1: After reset, the state code is 0 (Idle). The sample counter, the last write position, mem_wr and both interrupt outputs are 0.
- R2: Writing 1 into bits [7:0] of offset 0 while in Idle moves to state code 1. This clears the sample counter and loads the shots-remaining value. The state code is read at offset 1: Idle 0, Pre-trigger Count 1, Wait Trigger 2, Wait End of Shot 3, Decrement Shot Count 4.
- R3: In Pre-trigger Count, the sample counter rises by 2 for every packed word. The state moves to Wait Trigger once the counter is at least the pre-trigger count.
- R4: In Wait Trigger, the sample counter holds its value while packed words are still written to the buffer.
- R5: In Wait Trigger, either hw_trig or the command code 3 moves the state to Wait End of Shot. The next cycle carries a single-cycle irq_trig pulse.
- R6: Once the counter reaches pre plus post, the state passes through Decrement Shot Count. If more than one shot remains, the state returns to Pre-trigger Count with the counter at 0 and shots remaining decremented by one.
- R7: A trigger (hardware or code 3) arriving in any state other than Wait Trigger changes no state and raises no irq_trig.
- R8: Every two accepted samples produce one mem_wr cycle. For channel c, mem_data bits [32c+31:32c] hold the second sample zero-extended in the upper 16 bits and the first sample zero-extended in the lower 16 bits. mem_slot increases by one for each word and wraps modulo 2^DEPTH_W.
- R9: Writing 2 into bits [7:0] of offset 0 returns the machine to Idle from any state, without an irq_done pulse.
- R10: A shot count of 0 runs exactly one shot.
- R11: Bit 0 of the pre-trigger and post-trigger counts (offsets 2 and 3) is stored as 0, so both counts are always even.
- R12: Offset 7 reads the byte address of the last word written, which is the slot number times 4. This equals the channel-1 byte address in a per-channel view of the buffer.
- R13: Leaving Decrement Shot Count with one shot remaining gives Idle and a single-cycle irq_done pulse on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| hw_trig | input | 1 | Hardware trigger |
| smp_valid | input | 1 | One sample per channel is present |
| smp_data | input | NCH*SW | Channel samples, channel 0 in the low bits |
| mem_wr | output | 1 | Buffer word write |
| mem_slot | output | DEPTH_W | Circular buffer slot |
| mem_data | output | NCH*32 | Packed sample pairs, one 32-bit word per channel |
| irq_trig | output | 1 | Trigger-accepted pulse |
| irq_done | output | 1 | Final-shot-complete pulse |

## Verification
The bench builds the block with two channels of 12-bit samples, 8-bit counts and a 16-slot buffer. The narrow samples exercise zero-extension in the packed words. The short buffer means three acquisitions fill it past slot 15, so wrap-around and the last-position readback after a wrap both get checked. The small counts keep every phase of a two-shot run short enough to inspect state, counter and shots remaining at each transition. This includes a STOP issued during post-trigger counting and a shot count of zero.

// File: rtl/shot_pkg.sv
package shot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_WTRIG = 3'd2,
        ST_WEND  = 3'd3,
        ST_DEC   = 3'd4
    } shot_state_t;

    localparam logic [7:0] CMD_START = 8'd1;
    localparam logic [7:0] CMD_STOP  = 8'd2;
    localparam logic [7:0] CMD_SOFT  = 8'd3;

    localparam logic [2:0] RA_CMD   = 3'd0;
    localparam logic [2:0] RA_STATE = 3'd1;
    localparam logic [2:0] RA_PRE   = 3'd2;
    localparam logic [2:0] RA_POST  = 3'd3;
    localparam logic [2:0] RA_SHOTS = 3'd4;
    localparam logic [2:0] RA_CNT   = 3'd5;
    localparam logic [2:0] RA_LEFT  = 3'd6;
    localparam logic [2:0] RA_LAST  = 3'd7;

endpackage

// File: rtl/shot_regs.sv
module shot_regs
    import shot_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SHOT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_waddr,
    input  logic [31:0]       reg_wdata,
    input  logic [2:0]        reg_raddr,
    output logic [31:0]       reg_rdata,
    input  shot_state_t       state,
    input  logic [CNT_W:0]    cnt,
    input  logic [SHOT_W-1:0] left,
    input  logic [31:0]       last_pos,
    output logic [CNT_W-1:0]  pre_cfg,
    output logic [CNT_W-1:0]  post_cfg,
    output logic [SHOT_W-1:0] shots_cfg,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic              cmd_soft
);

    logic cmd_wr;
    assign cmd_wr    = reg_wr && (reg_waddr == RA_CMD);
    assign cmd_start = cmd_wr && (reg_wdata[7:0] == CMD_START);
    assign cmd_stop  = cmd_wr && (reg_wdata[7:0] == CMD_STOP);
    assign cmd_soft  = cmd_wr && (reg_wdata[7:0] == CMD_SOFT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cfg   <= '0;
            post_cfg  <= '0;
            shots_cfg <= '0;
        end else if (reg_wr) begin
            unique case (reg_waddr)
                RA_PRE:   pre_cfg   <= {reg_wdata[CNT_W-1:1], 1'b0};
                RA_POST:  post_cfg  <= {reg_wdata[CNT_W-1:1], 1'b0};
                RA_SHOTS: shots_cfg <= reg_wdata[SHOT_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_raddr)
            RA_STATE: reg_rdata = 32'(state);
            RA_PRE:   reg_rdata = 32'(pre_cfg);
            RA_POST:  reg_rdata = 32'(post_cfg);
            RA_SHOTS: reg_rdata = 32'(shots_cfg);
            RA_CNT:   reg_rdata = 32'(cnt);
            RA_LEFT:  reg_rdata = 32'(left);
            RA_LAST:  reg_rdata = last_pos;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/shot_fsm.sv
module shot_fsm
    import shot_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SHOT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_soft,
    input  logic              hw_trig,
    input  logic [CNT_W-1:0]  pre_cfg,
    input  logic [CNT_W-1:0]  post_cfg,
    input  logic [SHOT_W-1:0] shots_cfg,
    input  logic              word_done,
    output shot_state_t       state,
    output logic [CNT_W:0]    cnt,
    output logic [SHOT_W-1:0] left,
    output logic              cap_en,
    output logic              restart,
    output logic              irq_trig,
    output logic              irq_done
);

    localparam int TOT_W = CNT_W + 1;

    shot_state_t      nxt;
    logic [TOT_W-1:0] total;
    logic             pre_done;
    logic             post_done;
    logic             trig;
    logic             last_shot;

    assign total     = TOT_W'(pre_cfg) + TOT_W'(post_cfg);
    assign pre_done  = cnt >= TOT_W'(pre_cfg);
    assign post_done = cnt >= total;
    assign trig      = hw_trig || cmd_soft;
    assign last_shot = left <= SHOT_W'(1);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (cmd_start) nxt = ST_PRE;
            ST_PRE:   if (pre_done)  nxt = ST_WTRIG;
            ST_WTRIG: if (trig)      nxt = ST_WEND;
            ST_WEND:  if (post_done) nxt = ST_DEC;
            ST_DEC:   nxt = last_shot ? ST_IDLE : ST_PRE;
            default:  nxt = ST_IDLE;
        endcase
        if (cmd_stop) nxt = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign restart = !cmd_stop &&
                     (((state == ST_IDLE) && cmd_start) ||
                      ((state == ST_DEC) && !last_shot));

    assign cap_en = ((state == ST_PRE) && !pre_done) ||
                    (state == ST_WTRIG) ||
                    ((state == ST_WEND) && !post_done);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            left     <= '0;
            irq_trig <= 1'b0;
            irq_done <= 1'b0;
        end else begin
            irq_trig <= !cmd_stop && (state == ST_WTRIG) && trig;
            irq_done <= !cmd_stop && (state == ST_DEC) && last_shot;
            if (restart) begin
                cnt <= '0;
                if (state == ST_IDLE)
                    left <= (shots_cfg == '0) ? SHOT_W'(1) : shots_cfg;
                else
                    left <= left - SHOT_W'(1);
            end else if (word_done && (state != ST_WTRIG)) begin
                cnt <= cnt + TOT_W'(2);
            end
        end
    end

endmodule

// File: rtl/shot_packer.sv
module shot_packer #(
    parameter int NCH     = 4,
    parameter int SW      = 14,
    parameter int DEPTH_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic                 cap_en,
    input  logic                 smp_valid,
    input  logic [NCH*SW-1:0]    smp_data,
    output logic                 word_done,
    output logic                 mem_wr,
    output logic [DEPTH_W-1:0]   mem_slot,
    output logic [NCH*32-1:0]    mem_data,
    output logic [31:0]          last_pos
);

    logic               phase;
    logic [NCH*SW-1:0]  hold;
    logic [DEPTH_W-1:0] wptr;
    logic [NCH*32-1:0]  packed_w;

    assign word_done = smp_valid && cap_en && phase;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_pack
        assign packed_w[ch*32 +: 32] = {16'(smp_data[ch*SW +: SW]),
                                        16'(hold[ch*SW +: SW])};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= 1'b0;
            hold     <= '0;
            wptr     <= '0;
            mem_wr   <= 1'b0;
            mem_slot <= '0;
            mem_data <= '0;
            last_pos <= '0;
        end else begin
            mem_wr <= 1'b0;
            if (restart) begin
                phase <= 1'b0;
            end else if (smp_valid && cap_en) begin
                if (!phase) begin
                    hold  <= smp_data;
                    phase <= 1'b1;
                end else begin
                    phase    <= 1'b0;
                    mem_wr   <= 1'b1;
                    mem_slot <= wptr;
                    mem_data <= packed_w;
                    last_pos <= 32'({wptr, 2'b00});
                    wptr     <= wptr + DEPTH_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/shot_sequencer.sv
module shot_sequencer
    import shot_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int SW      = 14,
    parameter int DEPTH_W = 10,
    parameter int CNT_W   = 16,
    parameter int SHOT_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_waddr,
    input  logic [31:0]          reg_wdata,
    input  logic [2:0]           reg_raddr,
    output logic [31:0]          reg_rdata,
    input  logic                 hw_trig,
    input  logic                 smp_valid,
    input  logic [NCH*SW-1:0]    smp_data,
    output logic                 mem_wr,
    output logic [DEPTH_W-1:0]   mem_slot,
    output logic [NCH*32-1:0]    mem_data,
    output logic                 irq_trig,
    output logic                 irq_done
);

    shot_state_t       fsm_state;
    logic [CNT_W:0]    smp_cnt;
    logic [SHOT_W-1:0] shots_left;
    logic [31:0]       last_pos;
    logic [CNT_W-1:0]  pre_cfg;
    logic [CNT_W-1:0]  post_cfg;
    logic [SHOT_W-1:0] shots_cfg;
    logic              cmd_start;
    logic              cmd_stop;
    logic              cmd_soft;
    logic              cap_en;
    logic              restart;
    logic              word_done;

    shot_regs #(.CNT_W(CNT_W), .SHOT_W(SHOT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata),
        .state     (fsm_state),
        .cnt       (smp_cnt),
        .left      (shots_left),
        .last_pos  (last_pos),
        .pre_cfg   (pre_cfg),
        .post_cfg  (post_cfg),
        .shots_cfg (shots_cfg),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .cmd_soft  (cmd_soft)
    );

    shot_fsm #(.CNT_W(CNT_W), .SHOT_W(SHOT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .cmd_soft  (cmd_soft),
        .hw_trig   (hw_trig),
        .pre_cfg   (pre_cfg),
        .post_cfg  (post_cfg),
        .shots_cfg (shots_cfg),
        .word_done (word_done),
        .state     (fsm_state),
        .cnt       (smp_cnt),
        .left      (shots_left),
        .cap_en    (cap_en),
        .restart   (restart),
        .irq_trig  (irq_trig),
        .irq_done  (irq_done)
    );

    shot_packer #(.NCH(NCH), .SW(SW), .DEPTH_W(DEPTH_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .cap_en    (cap_en),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .word_done (word_done),
        .mem_wr    (mem_wr),
        .mem_slot  (mem_slot),
        .mem_data  (mem_data),
        .last_pos  (last_pos)
    );

endmodule

// File: rtl/shot_sequencer_chk.sv
module shot_sequencer_chk
    import shot_pkg::*;
#(
    parameter int DEPTH_W = 10,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input shot_state_t        state,
    input logic [CNT_W:0]     cnt,
    input logic               stop_cmd,
    input logic               irq_trig,
    input logic               irq_done,
    input logic               mem_wr,
    input logic [DEPTH_W-1:0] mem_slot,
    input logic [31:0]        last_pos
);

    // R9
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> (state == ST_IDLE));

    // R5
    trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_trig |=> !irq_trig);

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done);

    // R7
    trig_only_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_trig |-> ($past(state) == ST_WTRIG && state == ST_WEND));

    // R13
    done_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> (state == ST_IDLE && $past(state) == ST_DEC));

    // R4
    hold_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WTRIG && $past(state) == ST_WTRIG) |-> $stable(cnt));

    // R8
    pair_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    // R12
    last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (last_pos == 32'({mem_slot, 2'b00})));

    // R2
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state inside {ST_IDLE, ST_PRE, ST_WTRIG, ST_WEND, ST_DEC});

endmodule

bind shot_sequencer shot_sequencer_chk #(.DEPTH_W(DEPTH_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (fsm_state),
    .cnt      (smp_cnt),
    .stop_cmd (cmd_stop),
    .irq_trig (irq_trig),
    .irq_done (irq_done),
    .mem_wr   (mem_wr),
    .mem_slot (mem_slot),
    .last_pos (last_pos)
);

// File: tb/shot_sequencer_bench.sv
module shot_sequencer_bench;

    localparam int NCH     = 2;
    localparam int SW      = 12;
    localparam int DEPTH_W = 4;
    localparam int CNT_W   = 8;
    localparam int SHOT_W  = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_wr = 1'b0;
    logic [2:0]         reg_waddr = '0;
    logic [31:0]        reg_wdata = '0;
    logic [2:0]         reg_raddr = '0;
    logic [31:0]        reg_rdata;
    logic               hw_trig = 1'b0;
    logic               smp_valid = 1'b0;
    logic [NCH*SW-1:0]  smp_data = '0;
    logic               mem_wr;
    logic [DEPTH_W-1:0] mem_slot;
    logic [NCH*32-1:0]  mem_data;
    logic               irq_trig;
    logic               irq_done;

    shot_sequencer #(.NCH(NCH), .SW(SW), .DEPTH_W(DEPTH_W), .CNT_W(CNT_W),
                     .SHOT_W(SHOT_W)) u_shot_sequencer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .hw_trig(hw_trig), .smp_valid(smp_valid), .smp_data(smp_data),
        .mem_wr(mem_wr), .mem_slot(mem_slot), .mem_data(mem_data),
        .irq_trig(irq_trig), .irq_done(irq_done)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [DEPTH_W-1:0] slot;
        logic [NCH*32-1:0]  data;
    } exp_t;

    exp_t               sb[$];
    int                 n_chk = 0;
    int                 n_fail = 0;
    int                 trig_seen = 0;
    int                 done_seen = 0;
    int                 seq = 0;
    logic [DEPTH_W-1:0] exp_slot = '0;
    logic [31:0]        rv;

    function automatic logic [SW-1:0] sval(int s, int c);
        return SW'(s * 37 + c * 501 + 5);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(logic [2:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    // Driver: sends two samples per channel and queues the expected word.
    task automatic send_pair();
        logic [NCH*SW-1:0] a;
        logic [NCH*SW-1:0] b;
        exp_t              e;
        for (int c = 0; c < NCH; c++) begin
            a[c*SW +: SW] = sval(seq, c);
            b[c*SW +: SW] = sval(seq + 1, c);
            e.data[c*32 +: 32] = {16'(sval(seq + 1, c)), 16'(sval(seq, c))};
        end
        e.slot = exp_slot;
        @(negedge clk);
        smp_valid = 1'b1; smp_data = a;
        @(negedge clk);
        smp_data = b;
        sb.push_back(e);
        exp_slot = exp_slot + 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        seq += 2;
    endtask

    task automatic pulse_hw();
        @(negedge clk);
        hw_trig = 1'b1;
        @(negedge clk);
        hw_trig = 1'b0;
    endtask

    // Monitor: pops expected words as the design writes them (R8).
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_trig) trig_seen++;
            if (irq_done) done_seen++;
            if (mem_wr) begin
                n_chk++;
                if (sb.size() == 0) begin
                    n_fail++;
                    $display("FAIL R8 unexpected write: actual slot %0h expected none", mem_slot);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (mem_slot !== e.slot || mem_data !== e.data) begin
                        n_fail++;
                        $display("FAIL R8 word: actual %0h/%0h expected %0h/%0h",
                                 mem_slot, mem_data, e.slot, e.data);
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rreg(3'd1, rv); check("R1", rv, 0, "state");
        rreg(3'd5, rv); check("R1", rv, 0, "counter");
        rreg(3'd7, rv); check("R1", rv, 0, "last pos");
        check("R1", {29'd0, mem_wr, irq_trig, irq_done}, 0, "outputs");

        // R11 odd count stored even
        wreg(3'd2, 32'd5);
        rreg(3'd2, rv); check("R11", rv, 4, "pre count");
        wreg(3'd3, 32'd7);
        rreg(3'd3, rv); check("R11", rv, 6, "post count");
        wreg(3'd4, 32'd2);

        // R7 trigger in Idle ignored
        pulse_hw();
        tick(2);
        rreg(3'd1, rv); check("R7", rv, 0, "state after idle trig");
        check("R7", trig_seen, 0, "irq in idle");

        // R2 start
        wreg(3'd0, 32'd1);
        rreg(3'd1, rv); check("R2", rv, 1, "state after start");
        rreg(3'd5, rv); check("R2", rv, 0, "counter after start");
        rreg(3'd6, rv); check("R2", rv, 2, "shots left");

        // R7 software trigger in Pre-trigger Count ignored
        wreg(3'd0, 32'd3);
        tick(2);
        rreg(3'd1, rv); check("R7", rv, 1, "state after early trig");
        check("R7", trig_seen, 0, "irq after early trig");

        // R3 pre-trigger counting
        send_pair(); send_pair();
        rreg(3'd5, rv); check("R3", rv, 4, "counter at pre");
        tick(1);
        rreg(3'd1, rv); check("R3", rv, 2, "state wait trig");

        // R4 hold while waiting
        send_pair();
        rreg(3'd5, rv); check("R4", rv, 4, "counter in wait");

        // R5 hardware trigger
        pulse_hw();
        rreg(3'd1, rv); check("R5", rv, 3, "state after trig");
        tick(2);
        check("R5", trig_seen, 1, "trig pulses");

        // R6 next shot
        send_pair(); send_pair(); send_pair();
        rreg(3'd5, rv); check("R3", rv, 10, "counter at end");
        tick(2);
        rreg(3'd1, rv); check("R6", rv, 1, "state second shot");
        rreg(3'd5, rv); check("R6", rv, 0, "counter cleared");
        rreg(3'd6, rv); check("R6", rv, 1, "shots left");

        // second shot with software trigger, then R13 completion
        send_pair(); send_pair();
        tick(1);
        rreg(3'd1, rv); check("R3", rv, 2, "state wait trig 2");
        send_pair();
        wreg(3'd0, 32'd3);
        rreg(3'd1, rv); check("R5", rv, 3, "state after soft trig");
        send_pair(); send_pair(); send_pair();
        tick(2);
        rreg(3'd1, rv); check("R13", rv, 0, "idle after last shot");
        tick(2);
        check("R13", done_seen, 1, "done pulses");
        check("R5", trig_seen, 2, "trig pulses 2");
        rreg(3'd7, rv); check("R12", rv, 44, "last pos slot 11");

        // R10 zero shots means one shot
        wreg(3'd4, 32'd0);
        wreg(3'd0, 32'd1);
        rreg(3'd6, rv); check("R10", rv, 1, "shots left for zero");
        send_pair(); send_pair();
        tick(1);
        send_pair();
        pulse_hw();
        send_pair(); send_pair(); send_pair();
        tick(2);
        rreg(3'd1, rv); check("R10", rv, 0, "idle after single shot");
        tick(2);
        check("R10", done_seen, 2, "done pulses single");
        rreg(3'd7, rv); check("R12", rv, 4, "last pos after wrap");

        // R9 stop during post-trigger counting
        wreg(3'd4, 32'd3);
        wreg(3'd0, 32'd1);
        send_pair(); send_pair();
        tick(1);
        pulse_hw();
        send_pair();
        rreg(3'd1, rv); check("R9", rv, 3, "state before stop");
        wreg(3'd0, 32'd2);
        rreg(3'd1, rv); check("R9", rv, 0, "state after stop");
        tick(3);
        check("R9", done_seen, 2, "no done on stop");
        check("R5", trig_seen, 4, "trig pulses 3");
        rreg(3'd7, rv); check("R12", rv, 16, "last pos slot 4");

        tick(4);
        check("R8", 32'(sb.size()), 0, "pending words");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule